// File: doc/BRIEF.md
# Rounding Dual Multiply-Accumulate-High Unit

This unit reduces two 128-bit vectors, each holding four 32-bit lanes, to one 64-bit scalar. Every active lane multiplies a 32-bit element of the first vector by the matching element of the second. The 64-bit product is added to, or subtracted from, a 72-bit running sum. A rounding constant is added after each active lane. The sum starts from a 64-bit seed placed above eight guard bits. The result is the top 64 bits of the final sum, given as two 32-bit halves.

One operation is taken in through a valid/ready handshake. The operands, seed, per-byte predicate and mode bits are captured when `in_valid` and `in_ready` are both high on a clock edge. The unit then works through one lane per clock, in lane order 0 to 3. The result is offered with `res_valid` and held until the consumer raises `res_ready`. No new operation is accepted until the result has been taken, so a stalled consumer stalls the producer. A mode combination that has no meaning is not computed: it is reported at once with an illegal flag, and the result is the seed unchanged.

Top module: `rdmah_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_valid` is 0. An operation is accepted on any clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 1 only while the unit holds no operation.
- R2: For a legal mode, `res_valid` rises on the fourth clock edge after the accepting edge (LANES edges). While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_hi`, `res_lo` and `res_illegal` hold their values. The result is consumed on the edge where `res_valid` and `res_ready` are both 1.
- R3: In signed mode (`in_signed`=1), lane e adds the two's-complement product N[e]*M[e], taking element e from bits 32e+31:32e of each vector. The 64-bit seed is treated as signed.
- R4: In unsigned mode (`in_signed`=0, `in_xchg`=0, `in_sub`=0), operands, products and seed are zero-extended.
- R5: With `in_xchg`=1, an even lane e multiplies N[e+1] by M[e] and an odd lane e multiplies N[e-1] by M[e].
- R6: With `in_sub`=1, the products of even lanes are added and the products of odd lanes (1 and 3) are subtracted.
- R7: After each active lane's product has been added or subtracted, the constant 128 is added to the 72-bit sum.
- R8: Lane e is active exactly when `in_pred` bit 4e is 1 (bits 0, 4, 8, 12). An inactive lane changes nothing. The other 12 predicate bits are ignored.
- R9: The sum starts as the seed in bits 71:8 with zeros in bits 7:0. The result is `res_hi` = sum bits 71:40 and `res_lo` = sum bits 39:8.
- R10: The 72-bit sum wraps modulo 2^72 and never saturates.
- R11: If `in_signed`=0 together with `in_xchg`=1 or `in_sub`=1, `res_valid` rises on the edge after acceptance with `res_illegal`=1, and the result equals the seed. A legal operation gives `res_illegal`=0.
- R12: While an operation is in progress or its result is unconsumed, `in_ready` is 0. Any change on the data, predicate or mode inputs in that time has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered on the operand inputs |
| in_ready | output | 1 | The unit can accept an operation |
| in_vec_n | input | 128 | First vector, lane e in bits 32e+31:32e |
| in_vec_m | input | 128 | Second vector, same lane layout |
| in_seed | input | 64 | Accumulator seed (high part of the 72-bit sum) |
| in_pred | input | 16 | Per-byte predicate; bit 4e enables lane e |
| in_signed | input | 1 | 1 for two's-complement operands, 0 for unsigned |
| in_xchg | input | 1 | Cross-pair neighbouring lanes of the first vector |
| in_sub | input | 1 | Subtract the products of odd lanes |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer takes the result |
| res_hi | output | 32 | Sum bits 71:40 |
| res_lo | output | 32 | Sum bits 39:8 |
| res_illegal | output | 1 | The accepted mode combination was illegal |

## Verification
The assertions rely on reset being applied before the first operation. They also rely on the consumer following the handshake, that is, it never expects a result it has not waited for with `res_valid`. Mode and data inputs are assumed to matter only on the accepting edge. The bench keeps to these rules: it drives inputs shortly after a rising edge, holds `in_valid` with fixed operands until acceptance, and deliberately changes the operands and mode bits only while `in_ready` is low. Back-pressure is applied by lowering `res_ready` only while a result is outstanding.

// File: rtl/rdmah_pkg.sv
package rdmah_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rdmah_state_e;

  typedef struct packed {
    logic is_signed;
    logic xchg;
    logic sub_odd;
  } rdmah_mode_t;

endpackage

// File: rtl/rdmah_lane_mul.sv
module rdmah_lane_mul
  import rdmah_pkg::*;
#(
  parameter int EW    = 32,
  parameter int LANES = 4,
  parameter int ACC_W = 72
) (
  input  logic [EW*LANES-1:0]        vec_n,
  input  logic [EW*LANES-1:0]        vec_m,
  input  logic [$clog2(LANES)-1:0]   lane_idx,
  input  rdmah_mode_t                mode,
  output logic [ACC_W-1:0]           term
);
  localparam int LW = $clog2(LANES);
  localparam int PW = 2*EW + 2;

  logic [LW-1:0]        n_idx;
  logic [EW-1:0]        op_a;
  logic [EW-1:0]        op_b;
  logic signed [EW:0]   ext_a;
  logic signed [EW:0]   ext_b;
  logic signed [PW-1:0] prod;

  // exchange pairs lane e with its neighbour e^1 on the first vector (R5)
  assign n_idx = lane_idx ^ LW'(mode.xchg);
  assign op_a  = vec_n[n_idx*EW +: EW];
  assign op_b  = vec_m[lane_idx*EW +: EW];

  // one extra bit selects sign or zero extension (R3, R4)
  assign ext_a = $signed({mode.is_signed & op_a[EW-1], op_a});
  assign ext_b = $signed({mode.is_signed & op_b[EW-1], op_b});
  assign prod  = ext_a * ext_b;
  assign term  = {{(ACC_W-PW){prod[PW-1]}}, prod};

endmodule

// File: rtl/rdmah_acc.sv
module rdmah_acc #(
  parameter int ACC_W = 72,
  parameter int GUARD = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ACC_W-GUARD-1:0] seed,
  input  logic                   step,
  input  logic                   lane_act,
  input  logic                   negate,
  input  logic [ACC_W-1:0]       term,
  output logic [ACC_W-1:0]       acc_q
);
  localparam logic [ACC_W-1:0] RND = ACC_W'(1) << (GUARD-1);

  logic [ACC_W-1:0] addend;

  assign addend = negate ? (~term + ACC_W'(1)) : term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= {seed, {GUARD{1'b0}}};
    end else if (step && lane_act) begin
      acc_q <= acc_q + addend + RND;  // wraps modulo 2^ACC_W (R10)
    end
  end

  // R8: an inactive lane leaves the sum untouched
  p_skip_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lane_act && !load) |=> $stable(acc_q));

  // R7: a zero product still adds the rounding constant
  p_round_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lane_act && !load && term == '0) |=> acc_q == $past(acc_q) + RND);

  // R9: a load places the seed above the guard bits
  p_seed_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> acc_q == {$past(seed), {GUARD{1'b0}}});

endmodule

// File: rtl/rdmah_unit.sv
module rdmah_unit
  import rdmah_pkg::*;
#(
  parameter int EW    = 32,
  parameter int LANES = 4,
  parameter int GUARD = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EW*LANES-1:0]   in_vec_n,
  input  logic [EW*LANES-1:0]   in_vec_m,
  input  logic [2*EW-1:0]       in_seed,
  input  logic [EW*LANES/8-1:0] in_pred,
  input  logic                  in_signed,
  input  logic                  in_xchg,
  input  logic                  in_sub,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [EW-1:0]         res_hi,
  output logic [EW-1:0]         res_lo,
  output logic                  res_illegal
);
  localparam int VW    = EW*LANES;
  localparam int PPL   = EW/8;
  localparam int ACC_W = 2*EW + GUARD;
  localparam int LW    = $clog2(LANES);
  localparam logic [LW-1:0] LAST = LW'(LANES-1);

  rdmah_state_e     st_q;
  logic [LW-1:0]    lane_q;
  logic [VW-1:0]    vn_q;
  logic [VW-1:0]    vm_q;
  logic [LANES-1:0] act_q;
  rdmah_mode_t      mode_q;
  logic             ill_q;

  logic             accept;
  logic             illegal_in;
  logic [LANES-1:0] act_in;
  rdmah_mode_t      mode_in;
  logic             step;
  logic             lane_act;
  logic             negate;
  logic [ACC_W-1:0] term;
  logic [ACC_W-1:0] acc_q;

  // lane e is enabled by the predicate bit of its lowest byte (R8)
  for (genvar g = 0; g < LANES; g++) begin : g_pred
    assign act_in[g] = in_pred[g*PPL];
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign illegal_in = !in_signed && (in_xchg || in_sub);
  assign mode_in    = '{is_signed: in_signed, xchg: in_xchg, sub_odd: in_sub};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lane_q <= '0;
      vn_q   <= '0;
      vm_q   <= '0;
      act_q  <= '0;
      mode_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          vn_q   <= in_vec_n;
          vm_q   <= in_vec_m;
          act_q  <= act_in;
          mode_q <= mode_in;
          ill_q  <= illegal_in;
          lane_q <= '0;
          st_q   <= illegal_in ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          lane_q <= lane_q + LW'(1);
          if (lane_q == LAST) st_q <= ST_DONE;
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign step     = (st_q == ST_RUN);
  assign lane_act = act_q[lane_q];
  assign negate   = mode_q.sub_odd & lane_q[0];  // odd lanes subtract (R6)

  rdmah_lane_mul #(.EW(EW), .LANES(LANES), .ACC_W(ACC_W)) u_mul (
    .vec_n    (vn_q),
    .vec_m    (vm_q),
    .lane_idx (lane_q),
    .mode     (mode_q),
    .term     (term)
  );

  rdmah_acc #(.ACC_W(ACC_W), .GUARD(GUARD)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .seed     (in_seed),
    .step     (step),
    .lane_act (lane_act),
    .negate   (negate),
    .term     (term),
    .acc_q    (acc_q)
  );

  assign res_valid   = (st_q == ST_DONE);
  assign res_hi      = acc_q[ACC_W-1 -: EW];
  assign res_lo      = acc_q[GUARD +: EW];
  assign res_illegal = ill_q;

  // R12: once accepted, no further operation is taken until consumed
  p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2: a stalled result is held unchanged
  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hi)
                                   && $stable(res_lo) && $stable(res_illegal)));

  // R2: a legal operation is never answered on the next edge
  p_no_early_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !illegal_in) |=> !res_valid);

  // R11: an illegal mode is flagged at once with the seed as result
  p_illegal_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal_in) |=> (res_valid && res_illegal
                                && {res_hi, res_lo} == $past(in_seed)));

  // R1: ready and valid never overlap
  p_exclusive_hs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && res_valid));

endmodule

// File: tb/rdmah_unit_tb.sv
module rdmah_unit_tb_top;
  localparam int EW    = 32;
  localparam int LANES = 4;
  localparam int VW    = EW*LANES;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [VW-1:0]   in_vec_n = '0;
  logic [VW-1:0]   in_vec_m = '0;
  logic [63:0]     in_seed = '0;
  logic [15:0]     in_pred = '0;
  logic            in_signed = 1'b0;
  logic            in_xchg = 1'b0;
  logic            in_sub = 1'b0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic [EW-1:0]   res_hi;
  logic [EW-1:0]   res_lo;
  logic            res_illegal;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag = "R3";
  bit    finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rdmah_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec_n(in_vec_n), .in_vec_m(in_vec_m), .in_seed(in_seed),
    .in_pred(in_pred), .in_signed(in_signed), .in_xchg(in_xchg),
    .in_sub(in_sub), .res_valid(res_valid), .res_ready(res_ready),
    .res_hi(res_hi), .res_lo(res_lo), .res_illegal(res_illegal)
  );

  // behavioural reference of the whole operation
  function automatic logic [63:0] ref_calc(input logic [VW-1:0] n, input logic [VW-1:0] m,
                                           input logic [63:0] seed, input logic [15:0] pred,
                                           input bit sg, input bit xc, input bit sb);
    logic [71:0] acc;
    acc = {seed, 8'h00};
    for (int e = 0; e < LANES; e++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [63:0] pr;
      logic [71:0] p;
      if (pred[4*e]) begin
        a = xc ? n[(e ^ 1)*32 +: 32] : n[e*32 +: 32];
        b = m[e*32 +: 32];
        if (sg) begin
          pr = 64'(longint'(signed'(a)) * longint'(signed'(b)));
          p  = {{8{pr[63]}}, pr};
        end else begin
          pr = {32'h0, a} * {32'h0, b};
          p  = {8'h00, pr};
        end
        if (sb && (e % 2 == 1)) acc = acc - p;
        else                    acc = acc + p;
        acc = acc + 72'd128;
      end
    end
    return acc[71:8];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle model, compared and advanced on every falling edge
  int          m_st = 0;
  int          m_cnt = 0;
  logic [63:0] m_res = '0;
  bit          m_err = 1'b0;
  string       m_tag = "R3";

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1 in_ready", 64'(in_ready), 64'(m_st == 0));
      check("R2 res_valid", 64'(res_valid), 64'(m_st == 2));
      if (m_st == 2) begin
        check(m_tag, {res_hi, res_lo}, m_res);
        check("R11 illegal flag", 64'(res_illegal), 64'(m_err));
      end
      case (m_st)
        0: if (in_valid) begin
          if (!in_signed && (in_xchg || in_sub)) begin
            m_res = in_seed; m_err = 1'b1; m_st = 2;
          end else begin
            m_res = ref_calc(in_vec_n, in_vec_m, in_seed, in_pred, in_signed, in_xchg, in_sub);
            m_err = 1'b0; m_st = 1; m_cnt = LANES - 1;
          end
          m_tag = cur_tag;
        end
        1: if (m_cnt == 0) m_st = 2; else m_cnt--;
        default: if (res_ready) m_st = 0;
      endcase
    end
  end

  task automatic send(input logic [VW-1:0] n, input logic [VW-1:0] m, input logic [63:0] seed,
                      input logic [15:0] pred, input bit sg, input bit xc, input bit sb,
                      input bit hold);
    @(posedge clk); #2;
    in_vec_n = n; in_vec_m = m; in_seed = seed; in_pred = pred;
    in_signed = sg; in_xchg = xc; in_sub = sb; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    if (hold) begin
      // R12: scramble inputs while busy, R2: stall the result
      res_ready = 1'b0;
      for (int k = 0; k < LANES + 3; k++) begin
        in_vec_n = {$urandom, $urandom, $urandom, $urandom};
        in_vec_m = {$urandom, $urandom, $urandom, $urandom};
        in_seed  = {$urandom, $urandom};
        in_pred  = 16'($urandom);
        {in_signed, in_xchg, in_sub} = 3'($urandom);
        @(posedge clk); #2;
      end
      res_ready = 1'b1;
    end
    in_valid = 1'b0;
    do @(negedge clk); while (!res_valid);
    @(negedge clk);
  endtask

  function automatic logic [VW-1:0] vec4(input logic [31:0] e3, input logic [31:0] e2,
                                         input logic [31:0] e1, input logic [31:0] e0);
    return {e3, e2, e1, e0};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset ready", 64'(in_ready), 64'd1);
    check("R1 reset valid", 64'(res_valid), 64'd0);

    cur_tag = "R3 signed plain";
    send(vec4(32'd7, -32'sd3, 32'd1000, -32'sd5), vec4(-32'sd9, 32'd11, 32'd300, 32'd2),
         64'd5, 16'hFFFF, 1, 0, 0, 0);
    cur_tag = "R3 signed extremes";
    send({4{32'h8000_0000}}, {4{32'h8000_0000}}, 64'hFFFF_FFFF_FFFF_FFF0, 16'hFFFF, 1, 0, 0, 0);
    cur_tag = "R4 unsigned max";
    send({4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 64'h8000_0000_0000_0000, 16'hFFFF, 0, 0, 0, 0);
    cur_tag = "R5 exchange";
    send(vec4(32'd4, 32'd3, 32'd2, 32'd1), vec4(32'd1000, 32'd100, 32'd10, 32'd1),
         64'd0, 16'h1111, 1, 1, 0, 0);
    cur_tag = "R6 subtract odd";
    send(vec4(32'd50000, 32'd3, -32'sd70000, 32'd9), vec4(32'd40000, 32'd8, 32'd60000, 32'd6),
         64'd100, 16'hFFFF, 1, 0, 1, 0);
    cur_tag = "R6 subtract exchange";
    send(vec4(32'h1234_5678, -32'sd2, 32'h7FFF_FFFF, 32'd3), vec4(32'd5, 32'h8000_0000, 32'd7, -32'sd1),
         64'h0000_0001_0000_0000, 16'hFFFF, 1, 1, 1, 0);
    cur_tag = "R7 rounding only";
    send('0, '0, 64'd0, 16'hFFFF, 1, 0, 0, 0);
    cur_tag = "R7 rounding two lanes";
    send('0, '0, 64'd0, 16'h0101, 0, 0, 0, 0);
    cur_tag = "R8 off-lane bits ignored";
    send({4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 64'h0123_4567_89AB_CDEF, 16'hEEEE, 1, 0, 0, 0);
    check("R8 direct seed", {res_hi, res_lo}, 64'h0123_4567_89AB_CDEF);
    cur_tag = "R8 partial lanes";
    send(vec4(32'd9, 32'd8, 32'd7, 32'd6), vec4(32'd90, 32'd80, 32'd70, 32'd60),
         64'd0, 16'h1010, 1, 0, 0, 0);
    cur_tag = "R9 seed placement";
    send('0, '0, 64'hDEAD_BEEF_0BAD_F00D, 16'h0000, 0, 0, 0, 0);
    check("R9 hi field", 64'(res_hi), 64'hDEAD_BEEF);
    check("R9 lo field", 64'(res_lo), 64'h0BAD_F00D);
    cur_tag = "R10 wrap high";
    send({4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 0, 0, 0, 0);
    cur_tag = "R10 wrap signed";
    send({4{32'h7FFF_FFFF}}, {4{32'h7FFF_FFFF}}, 64'h7FFF_FFFF_FFFF_FFFF, 16'hFFFF, 1, 0, 0, 0);
    cur_tag = "R11 unsigned exchange";
    send({4{32'd3}}, {4{32'd3}}, 64'h1111_2222_3333_4444, 16'hFFFF, 0, 1, 0, 0);
    check("R11 seed returned", {res_hi, res_lo}, 64'h1111_2222_3333_4444);
    cur_tag = "R11 unsigned subtract";
    send({4{32'd3}}, {4{32'd3}}, 64'h5555_6666_7777_8888, 16'hFFFF, 0, 0, 1, 0);
    cur_tag = "R12 busy inputs ignored";
    send(vec4(32'd1, -32'sd2, 32'd3, -32'sd4), vec4(32'd5, 32'd6, -32'sd7, 32'd8),
         64'd42, 16'hFFFF, 1, 1, 0, 1);
    cur_tag = "R2 stalled result";
    send({4{32'hABCD_0123}}, {4{32'h0F0F_F0F0}}, 64'd9, 16'h0111, 0, 0, 0, 1);

    for (int i = 0; i < 40; i++) begin
      cur_tag = "R3 random mix";
      send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom}, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           (i % 7 == 3));
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule